// File: doc/BRIEF.md
# MDIO management frame controller

This block issues clause-22 style management frames to an Ethernet PHY over a two-wire interface: a clock (MDC) that the block drives and a bidirectional data line (MDIO) that it drives through an output-enable. Software writes one 32-bit word into the data register. That word is shifted out most significant bit first, exactly as written, including the start, opcode and turnaround fields. Before the word, the block sends a fixed run of ones as preamble.

For a read opcode, the block stops driving MDIO in time for the PHY to take the line. It collects the sixteen bits the PHY returns and places them in the low half of the data register. The block does not report progress through a busy flag. At the end of every frame it sets one bit in an event register, and software clears that bit by writing a one to it. The MDC rate comes from a divider register: one MDC period lasts twice the divider value in system clocks. A divider of zero keeps MDC still and prevents any frame from starting.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven (`mdio_oe` = 0), the event word reads zero and the data register reads zero.
- R2: A data register write while idle with a nonzero divider starts a frame. MDIO carries 32 ones and then the 32 bits of the written word, bit 31 first, one bit per MDC period.
- R3: While a frame runs, each MDC period lasts 2 × divider system clocks, with equal high and low halves. MDC stays low whenever no frame is running.
- R4: MDIO changes only on the falling edge of MDC, so every bit is stable across the rising edge where the PHY samples it.
- R5: When bits 29:28 of the word are 10 (read), the block stops driving MDIO from frame bit 16 (the second turnaround bit) through frame bit 0. Any other opcode drives all 64 bit times. Between frames MDIO is not driven.
- R6: For a read, the block samples MDIO at each MDC rising edge during frame bits 15 down to 0, most significant first. At frame end it writes the sixteen bits to data register bits 15:0 and leaves bits 31:16 unchanged. For any other opcode the register keeps the written word.
- R7: At frame end, event bit 23 becomes 1. A write to the event register with bit 23 set clears it. A write with bit 23 clear leaves it set. All other event bits read 0.
- R8: With the divider at 0, a data register write is stored but no frame starts: MDC does not toggle and the event bit stays clear.
- R9: A data register write while a frame is in progress is ignored. The frame on the wire and the register contents stay those of the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the data register |
| cmd_wdata | input | 32 | Frame word to load |
| cmd_q | output | 32 | Data register contents (read data lands in bits 15:0) |
| div_we | input | 1 | Write strobe for the MDC divider register |
| div_wdata | input | DIV_W | Divider value; 0 stops MDC |
| div_q | output | DIV_W | Divider register contents |
| evt_we | input | 1 | Write strobe for the event register (write-1-to-clear) |
| evt_wdata | input | 32 | Clear mask; a 1 in bit 23 clears the completion event |
| evt_q | output | 32 | Event register; bit 23 marks frame completion |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The bench builds the block with its default parameters: a 6-bit divider, a 32-bit preamble and the event at bit 23. It sweeps divider values 1 through 4, which covers the single-clock half period, where MDC toggles every system clock. At every divider it runs read and write frames with arithmetically varied PHY addresses, register numbers, data and PHY responses. A PHY model records all 64 bit times and the per-bit output-enable. This lets the bench compare every preamble bit, the exact release point of the turnaround, the captured response and the total MDC span against values computed from the divider. The bench also covers a zero divider, a second write during a frame, and event writes with and without the clearing bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int unsigned FRM_W   = 32;
   localparam int unsigned RD_W    = 16;
   localparam logic [1:0]  OP_READ = 2'b10;
   // frame bit index (from MSB = 0) where the block lets go of MDIO on a read
   localparam int unsigned REL_IDX = 15;
   // frame bit index of the first returned data bit
   localparam int unsigned CAP_IDX = 16;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);
   logic [DIV_W-1:0] half_cnt;
   logic             hit;

   assign hit      = run && (div != '0) && (half_cnt == div - 1'b1);
   assign rise_stb = hit && !mdc;
   assign fall_stb = hit && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         mdc      <= 1'b0;
      end else if (!run) begin
         half_cnt <= '0;
         mdc      <= 1'b0;
      end else if (hit) begin
         half_cnt <= '0;
         mdc      <= ~mdc;
      end else begin
         half_cnt <= half_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [FRM_W-1:0] word,
   input  logic             rise_stb,
   input  logic             fall_stb,
   input  logic             mdio_i,
   output logic             busy,
   output logic             done,
   output logic [RD_W-1:0]  rd_data,
   output logic             mdio_o,
   output logic             mdio_oe
);
   localparam int unsigned TOT = PRE_LEN + FRM_W;
   localparam int unsigned CW  = $clog2(TOT + 1);
   localparam logic [CW-1:0] LAST_BIT = CW'(TOT - 1);
   localparam logic [CW-1:0] REL_BIT  = CW'(PRE_LEN + REL_IDX);
   localparam logic [CW-1:0] CAP_BIT  = CW'(PRE_LEN + CAP_IDX);

   seq_state_t       state;
   logic [CW-1:0]    bcnt;
   logic [FRM_W-1:0] sh;
   logic             is_rd;
   logic [RD_W-1:0]  cap;
   logic             in_pre;

   generate
      if (PRE_LEN == 0) begin : g_no_pre
         assign in_pre = 1'b0;
      end else begin : g_pre
         assign in_pre = (bcnt < CW'(PRE_LEN));
      end
   endgenerate

   assign busy    = (state == SEQ_RUN);
   assign done    = busy && fall_stb && (bcnt == LAST_BIT);
   assign rd_data = cap;
   assign mdio_o  = !busy || in_pre || sh[FRM_W-1];
   assign mdio_oe = busy && !(is_rd && (bcnt >= REL_BIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         bcnt  <= '0;
         sh    <= '0;
         is_rd <= 1'b0;
         cap   <= '0;
      end else if (!busy) begin
         if (launch) begin
            state <= SEQ_RUN;
            bcnt  <= '0;
            sh    <= word;
            is_rd <= (word[29:28] == OP_READ);
         end
      end else begin
         if (rise_stb && is_rd && (bcnt >= CAP_BIT)) begin
            cap <= {cap[RD_W-2:0], mdio_i};
         end
         if (fall_stb) begin
            if (bcnt == LAST_BIT) begin
               state <= SEQ_IDLE;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
            if (!in_pre) begin
               sh <= {sh[FRM_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/mdio_evt_reg.sv
module mdio_evt_reg #(
   parameter int unsigned W       = 32,
   parameter int unsigned EVT_BIT = 23
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set,
   input  logic         clr_we,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] evt
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i == EVT_BIT) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  evt[i] <= 1'b0;
               end else if (set) begin
                  evt[i] <= 1'b1;
               end else if (clr_we && clr_mask[i]) begin
                  evt[i] <= 1'b0;
               end
            end
         end else begin : g_dead
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  evt[i] <= 1'b0;
               end else if (clr_we && clr_mask[i]) begin
                  evt[i] <= 1'b0;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
   import mdio_pkg::*;
#(
   parameter int unsigned DIV_W   = 6,
   parameter int unsigned PRE_LEN = 32,
   parameter int unsigned EVT_BIT = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [31:0]      cmd_wdata,
   output logic [31:0]      cmd_q,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   output logic [DIV_W-1:0] div_q,
   input  logic             evt_we,
   input  logic [31:0]      evt_wdata,
   output logic [31:0]      evt_q,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("mdio_frame_ctrl: DIV_W must lie in 1..16");
      end
      if (EVT_BIT > 31) begin : g_bad_evt
         $error("mdio_frame_ctrl: EVT_BIT must address a bit of a 32-bit word");
      end
      if (PRE_LEN > 64) begin : g_bad_pre
         $error("mdio_frame_ctrl: PRE_LEN above 64 is not supported");
      end
   endgenerate

   logic            busy;
   logic            done;
   logic            launch;
   logic            rise_stb;
   logic            fall_stb;
   logic [RD_W-1:0] rd_data;

   assign launch = cmd_we && !busy && (div_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (div_we) begin
         div_q <= div_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (cmd_we && !busy) begin
         cmd_q <= cmd_wdata;
      end else if (done && (cmd_q[29:28] == OP_READ)) begin
         cmd_q[RD_W-1:0] <= rd_data;
      end
   end

   mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (div_q),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .word     (cmd_wdata),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .done     (done),
      .rd_data  (rd_data),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   mdio_evt_reg #(.W(32), .EVT_BIT(EVT_BIT)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (done),
      .clr_we   (evt_we),
      .clr_mask (evt_wdata),
      .evt      (evt_q)
   );
endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk #(
   parameter int unsigned DIV_W   = 6,
   parameter int unsigned EVT_BIT = 23
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             mdc,
   input logic             mdio_o,
   input logic             mdio_oe,
   input logic [DIV_W-1:0] div_q,
   input logic [31:0]      cmd_q,
   input logic [31:0]      evt_q
);
   p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   p_mdio_stable_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

   p_evt_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> evt_q[EVT_BIT]);

   p_no_launch_div0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (div_q == '0)) |=> !busy);

   p_cmd_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(cmd_q));
endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk #(.DIV_W(DIV_W), .EVT_BIT(EVT_BIT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .div_q   (div_q),
   .cmd_q   (cmd_q),
   .evt_q   (evt_q)
);

// File: tb/mdio_frame_ctrl_test.sv
module mdio_frame_ctrl_test;
   localparam int DIV_W = 6;
   localparam int EB    = 23;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_we = 1'b0;
   logic [31:0]      cmd_wdata = '0;
   logic [31:0]      cmd_q;
   logic             div_we = 1'b0;
   logic [DIV_W-1:0] div_wdata = '0;
   logic [DIV_W-1:0] div_q;
   logic             evt_we = 1'b0;
   logic [31:0]      evt_wdata = '0;
   logic [31:0]      evt_q;
   logic             mdc, mdio_o, mdio_oe, mdio_i;

   int          checks = 0;
   int          failures = 0;
   int          cyc = 0;
   bit          finished = 1'b0;
   int          rc = 0;
   logic [15:0] resp = '0;
   logic [63:0] got_bits = '0;
   logic [63:0] got_oe = '0;
   int          first_rise = 0;
   int          last_rise = 0;

   always #10 clk = ~clk;

   mdio_frame_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q),
      .div_we(div_we), .div_wdata(div_wdata), .div_q(div_q),
      .evt_we(evt_we), .evt_wdata(evt_wdata), .evt_q(evt_q),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY responder: drives data bits 15..0 for rise indices 48..63
   always_comb begin
      if (rc >= 48 && rc < 64) mdio_i = resp[63 - rc];
      else                     mdio_i = 1'b1;
   end

   always @(posedge mdc) begin
      got_bits = {got_bits[62:0], mdio_o};
      got_oe   = {got_oe[62:0], mdio_oe};
      if (rc == 0) first_rise = cyc;
      last_rise = cyc;
      rc = rc + 1;
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !finished) begin
         checks   = checks + 1;
         failures = failures + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cyc);
         summary();
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_cmd(input logic [31:0] w);
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
      @(negedge clk); cmd_we = 1'b0;
   endtask

   task automatic wr_div(input int d);
      @(negedge clk); div_we = 1'b1; div_wdata = DIV_W'(d);
      @(negedge clk); div_we = 1'b0;
   endtask

   task automatic wr_evt(input logic [31:0] m);
      @(negedge clk); evt_we = 1'b1; evt_wdata = m;
      @(negedge clk); evt_we = 1'b0;
   endtask

   task automatic wait_evt(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (evt_q[EB]) begin seen = 1'b1; break; end
      end
   endtask

   task automatic run_frame(input logic [31:0] w, input logic [15:0] r, input int d);
      bit          seen;
      logic        rd;
      logic [63:0] exp_oe;
      rd = (w[29:28] == 2'b10);
      resp = r;
      rc = 0;
      wr_cmd(w);
      wait_evt(seen);
      check("R7 event set at frame end", 64'(seen), 64'd1);
      check("R2 bit count", 64'(rc), 64'd64);
      check("R2 preamble and word", got_bits, {32'hFFFF_FFFF, w});
      check("R3 MDC span", 64'(last_rise - first_rise), 64'(63 * 2 * d));
      exp_oe = rd ? {{47{1'b1}}, {17{1'b0}}} : {64{1'b1}};
      check("R5 output enable per bit", got_oe, exp_oe);
      check("R6 data register after frame", 64'(cmd_q), 64'(rd ? {w[31:16], r} : w));
      check("R3 MDC low after frame", 64'(mdc), 64'd0);
      wr_evt(32'h1 << EB);
      check("R7 event cleared by write-1", 64'(evt_q), 64'd0);
   endtask

   initial begin
      bit seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 mdc", 64'(mdc), 64'd0);
      check("R1 mdio_oe", 64'(mdio_oe), 64'd0);
      check("R1 evt_q", 64'(evt_q), 64'd0);
      check("R1 cmd_q", 64'(cmd_q), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 divider zero: stored, never launched
      rc = 0;
      wr_cmd(32'h6082_0000);
      repeat (300) @(negedge clk);
      check("R8 no MDC edges", 64'(rc), 64'd0);
      check("R8 no event", 64'(evt_q), 64'd0);
      check("R8 word stored", 64'(cmd_q), 64'h6082_0000);
      check("R5 released while idle", 64'(mdio_oe), 64'd0);

      // R2 R3 R4 R5 R6 sweep over divider, opcode and fields
      for (int d = 1; d <= 4; d++) begin
         wr_div(d);
         for (int i = 0; i < 6; i++) begin
            logic [4:0]  pa;
            logic [4:0]  ra;
            logic [15:0] dv;
            logic [15:0] rs;
            logic [31:0] w;
            pa = 5'((d * 7 + i * 5) % 32);
            ra = 5'((i * 11 + d * 3) % 32);
            dv = 16'hA5C3 ^ 16'(i * 16'h1111 + d);
            rs = 16'h3C5A ^ 16'(i * 16'h0F0F + d * 16'h0101);
            if (i % 2 == 0) w = 32'h6002_0000 | (32'(pa) << 23) | (32'(ra) << 18);
            else            w = 32'h5002_0000 | (32'(pa) << 23) | (32'(ra) << 18) | 32'(dv);
            run_frame(w, rs, d);
         end
      end

      // R7 a write without bit 23 leaves the event set
      wr_div(2);
      resp = 16'h0; rc = 0;
      wr_cmd(32'h5002_1234);
      wait_evt(seen);
      wr_evt(~(32'h1 << EB));
      check("R7 event kept by write-0", 64'(evt_q), 64'(32'h1 << EB));
      wr_evt(32'h1 << EB);
      check("R7 event cleared", 64'(evt_q), 64'd0);

      // R9 write during a frame is ignored
      rc = 0;
      wr_cmd(32'h5112_BEEF);
      repeat (100) @(negedge clk);
      wr_cmd(32'h60FE_0000);
      wait_evt(seen);
      check("R9 wire carries first word", got_bits, {32'hFFFF_FFFF, 32'h5112_BEEF});
      check("R9 register keeps first word", 64'(cmd_q), 64'h5112_BEEF);
      repeat (20) @(negedge clk);
      check("R9 no second frame", 64'(rc), 64'd64);

      summary();
   end
endmodule